// File: doc/BRIEF.md
# SMBus Host Status Register

This block holds the 8-bit status word of an SMBus host controller. It sits between a simple register access port and the transaction engine. Single-cycle event pulses from the engine set sticky status flags: successful completion, device error, bus collision and kill-terminated failure. A pulse on the alert input sets a further flag. Software clears any of these flags by writing a 1 to its bit position. From the flags the block derives an interrupt request.

Bit 6 is a software ownership semaphore. A read returns its current value and then sets it. Writing a 1 releases it. Software threads poll it until they read 0, and the thread that reads 0 owns the controller. Bit 0 is a hardware busy flag that is high while a host command runs. While busy is high, the block flags accesses to other host registers as illegal. The one exception is the block-data byte register, and only when the programmed command is a block transfer or an I2C read.

The alert flag lives in the resume reset domain. The main reset leaves it unchanged, and only the resume reset clears it. Each reset input asserts asynchronously and is released through its own synchronizer. The read data always shows the current status word.

Top module: `smb_host_stat`

## Requirements
- R1: While `rst_n` and `rsm_rst_n` are low, `rd_data` reads 0x00, and `irq`, `busy` and `acc_illegal` are 0.
- R2: Bit 6 (semaphore) returns its value before the read, and is 1 from the cycle after a rising edge of `sel & rd_stb`. Holding the read strobe high gives only one set, so a release written during a held read leaves bit 6 at 0.
- R3: Writing `wr_data[6]`=1 with `sel & wr_stb` clears bit 6 on the next cycle. Writing 0 there has no effect. If a read edge and such a write happen in the same cycle, the read wins.
- R4: One cycle after a pulse, the matching bit is 1: `ev_done` sets bit 1, `ev_deverr` sets bit 2, `ev_coll` sets bit 3 and `ev_kill` sets bit 4. This happens whatever the value of `int_en`.
- R5: A status write clears each of bits 1 to 5 whose `wr_data` bit is 1, on the next cycle. Bits whose `wr_data` bit is 0 keep their value.
- R6: When a set event and a write-1 clear hit the same bit in the same cycle, the bit is 1 afterwards.
- R7: An `alert_evt` pulse sets bit 5 one cycle later, unless `alert_gpio` is 1. Bit 5 is cleared only by a write of 1 or by `rsm_rst_n` low. `rst_n` does not clear it.
- R8: Bit 0 and `busy` become 1 the cycle after `cmd_start`. They become 0 the cycle after any of `ev_done`, `ev_deverr`, `ev_coll` or `ev_kill`, unless `cmd_start` is also high in that cycle. Writes to bit 0 have no effect, and bit 7 always reads 0.
- R9: `irq` = `int_en & (bit1|bit2|bit3|bit4|(bit5 & alert_to_int))`. It is combinational on the stored bits.
- R10: `acc_illegal` = `busy & acc_other & ~(acc_blkdat & cmd_blk_rd)`. It is combinational within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Main asynchronous active-low reset |
| rsm_rst_n | input | 1 | Resume-domain asynchronous active-low reset (bit 5) |
| sel | input | 1 | Status register addressed |
| rd_stb | input | 1 | Read strobe |
| wr_stb | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Current status word |
| cmd_start | input | 1 | Host command starts |
| ev_done | input | 1 | Command completed successfully |
| ev_deverr | input | 1 | Illegal command, unclaimed cycle or device time-out |
| ev_coll | input | 1 | Bus collision |
| ev_kill | input | 1 | Transaction ended by kill |
| alert_evt | input | 1 | Alert input event |
| alert_gpio | input | 1 | Alert pin used as general-purpose I/O |
| int_en | input | 1 | Interrupt enable |
| alert_to_int | input | 1 | Alert routed to interrupt |
| acc_other | input | 1 | Access to another host register |
| acc_blkdat | input | 1 | That access targets the block-data register |
| cmd_blk_rd | input | 1 | Programmed command is block or I2C read |
| busy | output | 1 | Host command running |
| irq | output | 1 | Interrupt request |
| acc_illegal | output | 1 | Access not allowed during busy |

## Verification
Every stored bit (0 to 6) changes on the first clock edge after its stimulus, so its value is due in the following low phase. `irq` and `acc_illegal` follow the stored bits and the level inputs with no delay. Reset assertion takes effect at once, and reset release takes two extra edges. The bench drives inputs on the falling edge and compares every output against a behavioural model shortly after that. It then advances the model on the rising edge, so each check looks at the cycle in which the result is due.

// File: rtl/smb_stat_pkg.sv
package smb_stat_pkg;
  localparam int ST_W    = 8;
  localparam int B_BUSY  = 0;
  localparam int B_DONE  = 1;
  localparam int B_DEV   = 2;
  localparam int B_COLL  = 3;
  localparam int B_KILL  = 4;
  localparam int B_ALERT = 5;
  localparam int B_SEM   = 6;
  localparam int N_EVT   = B_KILL - B_DONE + 1;

  typedef struct packed {
    logic kill;
    logic coll;
    logic dev;
    logic done;
  } evt_t;
endpackage

// File: rtl/smb_rst_sync.sv
module smb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sh_q[STAGES-1];
endmodule

// File: rtl/smb_sticky_bits.sv
module smb_sticky_bits #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic en, d;
    // set has priority over clear (R6)
    always_comb begin
      en = set_i[i] | clr_i[i];
      d  = set_i[i];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q[i] <= 1'b0;
      else if (en) q[i] <= d;
    end
  end
endmodule

// File: rtl/smb_semaphore.sv
module smb_semaphore (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_lvl,
  input  logic rel,
  output logic q
);
  logic rd_q, fire, en, d;

  always_comb begin
    fire = rd_lvl & ~rd_q;   // one side effect per read strobe (R2)
    en   = fire | rel;
    d    = fire;             // read wins over release (R3)
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= 1'b0;
      q    <= 1'b0;
    end else begin
      rd_q <= rd_lvl;
      if (en) q <= d;
    end
  end
endmodule

// File: rtl/smb_host_stat.sv
module smb_host_stat
  import smb_stat_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rsm_rst_n,
  input  logic            sel,
  input  logic            rd_stb,
  input  logic            wr_stb,
  input  logic [ST_W-1:0] wr_data,
  output logic [ST_W-1:0] rd_data,
  input  logic            cmd_start,
  input  logic            ev_done,
  input  logic            ev_deverr,
  input  logic            ev_coll,
  input  logic            ev_kill,
  input  logic            alert_evt,
  input  logic            alert_gpio,
  input  logic            int_en,
  input  logic            alert_to_int,
  input  logic            acc_other,
  input  logic            acc_blkdat,
  input  logic            cmd_blk_rd,
  output logic            busy,
  output logic            irq,
  output logic            acc_illegal
);
  logic srst_n, rsm_srst_n;
  logic wr_en, rd_lvl, term;
  evt_t evt;
  logic [N_EVT-1:0] evt_clr, evt_q;
  logic [0:0] alr_set, alr_clr, alr_q;
  logic sem_q, busy_q, busy_en, busy_d;

  smb_rst_sync #(.STAGES(SYNC_STAGES)) u_sync_main (
    .clk(clk), .arst_n(rst_n), .srst_n(srst_n));
  smb_rst_sync #(.STAGES(SYNC_STAGES)) u_sync_rsm (
    .clk(clk), .arst_n(rsm_rst_n), .srst_n(rsm_srst_n));

  always_comb begin
    wr_en   = sel & wr_stb;
    rd_lvl  = sel & rd_stb;
    evt     = '{kill: ev_kill, coll: ev_coll, dev: ev_deverr, done: ev_done};
    evt_clr = {N_EVT{wr_en}} & wr_data[B_KILL:B_DONE];
    alr_set = alert_evt & ~alert_gpio;
    alr_clr = wr_en & wr_data[B_ALERT];
    term    = ev_done | ev_deverr | ev_coll | ev_kill;
  end

  // R4, R5, R6: transaction outcome flags
  smb_sticky_bits #(.N(N_EVT)) u_evt (
    .clk(clk), .rst_n(srst_n), .set_i(evt), .clr_i(evt_clr), .q(evt_q));

  // R7: alert flag in the resume reset domain
  smb_sticky_bits #(.N(1)) u_alert (
    .clk(clk), .rst_n(rsm_srst_n), .set_i(alr_set), .clr_i(alr_clr), .q(alr_q));

  // R2, R3: ownership semaphore
  smb_semaphore u_sem (
    .clk(clk), .rst_n(srst_n), .rd_lvl(rd_lvl),
    .rel(wr_en & wr_data[B_SEM]), .q(sem_q));

  // R8: busy next state; start wins over termination
  always_comb begin
    busy_en = cmd_start | term;
    busy_d  = cmd_start;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)      busy_q <= 1'b0;
    else if (busy_en) busy_q <= busy_d;
  end

  // R1, R8, R9, R10: outputs
  always_comb begin
    rd_data     = {1'b0, sem_q, alr_q, evt_q, busy_q};
    busy        = busy_q;
    irq         = int_en & ((|evt_q) | (alr_q[0] & alert_to_int));
    acc_illegal = busy_q & acc_other & ~(acc_blkdat & cmd_blk_rd);
  end
endmodule

// File: rtl/smb_host_stat_chk.sv
module smb_host_stat_chk (
  input logic       clk,
  input logic       srst_n,
  input logic       rsm_srst_n,
  input logic       sel,
  input logic       rd_stb,
  input logic       wr_stb,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic       cmd_start,
  input logic       ev_done,
  input logic       ev_deverr,
  input logic       ev_coll,
  input logic       alert_evt,
  input logic       alert_gpio,
  input logic       int_en,
  input logic       irq,
  input logic       acc_illegal
);
  assert_sem_set_R2: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(sel && rd_stb) |=> rd_data[6]);

  assert_done_set_R4: assert property (@(posedge clk) disable iff (!srst_n)
    ev_done |=> rd_data[1]);

  assert_coll_clear_R5: assert property (@(posedge clk) disable iff (!srst_n)
    (sel && wr_stb && wr_data[3] && !ev_coll) |=> !rd_data[3]);

  assert_set_wins_R6: assert property (@(posedge clk) disable iff (!srst_n)
    (sel && wr_stb && wr_data[2] && ev_deverr) |=> rd_data[2]);

  assert_gpio_block_R7: assert property (@(posedge clk) disable iff (!rsm_srst_n)
    (!rd_data[5] && (alert_gpio || !alert_evt)) |=> !rd_data[5]);

  assert_busy_set_R8: assert property (@(posedge clk) disable iff (!srst_n)
    cmd_start |=> rd_data[0]);

  assert_bit7_zero_R8: assert property (@(posedge clk) disable iff (!srst_n)
    !rd_data[7]);

  assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!srst_n)
    irq |-> int_en);

  assert_illegal_busy_R10: assert property (@(posedge clk) disable iff (!srst_n)
    acc_illegal |-> rd_data[0]);
endmodule

bind smb_host_stat smb_host_stat_chk u_chk (
  .clk(clk), .srst_n(srst_n), .rsm_srst_n(rsm_srst_n), .sel(sel),
  .rd_stb(rd_stb), .wr_stb(wr_stb), .wr_data(wr_data), .rd_data(rd_data),
  .cmd_start(cmd_start), .ev_done(ev_done), .ev_deverr(ev_deverr),
  .ev_coll(ev_coll), .alert_evt(alert_evt), .alert_gpio(alert_gpio),
  .int_en(int_en), .irq(irq), .acc_illegal(acc_illegal));

// File: tb/tb_smb_host_stat.sv
module tb_smb_host_stat;
  logic clk = 1'b0;
  logic rst_n, rsm_rst_n, sel, rd_stb, wr_stb;
  logic [7:0] wr_data, rd_data;
  logic cmd_start, ev_done, ev_deverr, ev_coll, ev_kill;
  logic alert_evt, alert_gpio, int_en, alert_to_int;
  logic acc_other, acc_blkdat, cmd_blk_rd;
  logic busy, irq, acc_illegal;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // behavioural reference state
  bit m_busy, m_sem, m_rdq, m_alert;
  bit [4:1] m_evt;

  always #5 clk = ~clk;

  smb_host_stat dut (.*);

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle();
    sel = 0; rd_stb = 0; wr_stb = 0; wr_data = 8'h00;
    cmd_start = 0; ev_done = 0; ev_deverr = 0; ev_coll = 0; ev_kill = 0;
    alert_evt = 0; acc_other = 0; acc_blkdat = 0; cmd_blk_rd = 0;
  endtask

  // compare outputs now, then advance model on the rising edge
  task automatic step();
    bit any;
    bit rd_lvl, fire, wr_en;
    #2;
    if (!rst_n) begin
      m_busy = 0; m_sem = 0; m_rdq = 0; m_evt = '0;
    end
    if (!rsm_rst_n) m_alert = 0;
    any = (m_evt != 0) || (m_alert && alert_to_int);
    chk("R8 bit7", int'(rd_data[7]), 0);
    chk("R2/R3 sem", int'(rd_data[6]), int'(m_sem));
    chk("R7 alert", int'(rd_data[5]), int'(m_alert));
    chk("R4/R5/R6 flags", int'(rd_data[4:1]), int'(m_evt));
    chk("R8 busy", int'({rd_data[0], busy}), int'({m_busy, m_busy}));
    chk("R9 irq", int'(irq), int'(int_en && any));
    chk("R10 illegal", int'(acc_illegal),
        int'(m_busy && acc_other && !(acc_blkdat && cmd_blk_rd)));
    @(posedge clk);
    rd_lvl = sel && rd_stb;
    wr_en  = sel && wr_stb;
    if (rst_n) begin
      fire = rd_lvl && !m_rdq;
      m_rdq = rd_lvl;
      if (fire) m_sem = 1;
      else if (wr_en && wr_data[6]) m_sem = 0;
      for (int i = 1; i <= 4; i++) begin
        bit s;
        s = (i == 1) ? ev_done : (i == 2) ? ev_deverr : (i == 3) ? ev_coll : ev_kill;
        if (s) m_evt[i] = 1;
        else if (wr_en && wr_data[i]) m_evt[i] = 0;
      end
      if (cmd_start) m_busy = 1;
      else if (ev_done || ev_deverr || ev_coll || ev_kill) m_busy = 0;
    end
    if (rsm_rst_n) begin
      if (alert_evt && !alert_gpio) m_alert = 1;
      else if (wr_en && wr_data[5]) m_alert = 0;
    end
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    sel = 1; wr_stb = 1; wr_data = d; step(); idle();
  endtask

  initial begin
    #200000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    idle();
    int_en = 0; alert_to_int = 0; alert_gpio = 0;
    rst_n = 0; rsm_rst_n = 0;
    @(negedge clk);
    // R1: reset state
    repeat (3) step();
    chk("R1 reset rd_data", int'(rd_data), 0);
    rst_n = 1; rsm_rst_n = 1;
    repeat (3) step();

    // R4: events set flags with interrupt disabled; R9 irq stays low
    ev_done = 1; step(); idle();
    ev_deverr = 1; step(); idle();
    ev_coll = 1; ev_kill = 1; step(); idle();
    chk("R4 all flags set", int'(rd_data[4:1]), 4'hF);
    chk("R9 irq off when disabled", int'(irq), 0);
    int_en = 1; step();
    chk("R9 irq with enable", int'(irq), 1);

    // R5: write 0 does nothing, write 1 clears selected bits
    wr(8'h00);
    wr(8'h0A);
    chk("R5 partial clear", int'(rd_data[4:1]), 4'b1010);
    wr(8'h14);
    step();
    chk("R5 all clear, R9 irq low", int'({rd_data[4:1], irq}), 0);

    // R6: set and clear collide
    sel = 1; wr_stb = 1; wr_data = 8'h08; ev_coll = 1; step(); idle();
    step();
    chk("R6 set wins", int'(rd_data[3]), 1);
    wr(8'h08);

    // R8: busy, ignored write to bit 0, bit 7
    cmd_start = 1; step(); idle();
    wr(8'h81);
    chk("R8 busy survives write", int'(busy), 1);
    // R10: access checks during busy
    acc_other = 1; step();
    chk("R10 illegal other", int'(acc_illegal), 1);
    acc_blkdat = 1; step();
    cmd_blk_rd = 1; step();
    chk("R10 blkdat allowed", int'(acc_illegal), 0);
    acc_blkdat = 0; step(); idle();
    ev_kill = 1; step(); idle();
    step();
    chk("R8 busy cleared by kill", int'(busy), 0);
    acc_other = 1; step(); idle();
    cmd_start = 1; step();
    ev_done = 1; step(); idle();
    step();
    chk("R8 start wins over end", int'(busy), 1);
    ev_coll = 1; step(); idle();
    wr(8'h1E);

    // R2/R3: semaphore
    sel = 1; rd_stb = 1; step();
    step();
    chk("R2 read sets sem", int'(rd_data[6]), 1);
    wr_stb = 1; wr_data = 8'h40; step(); wr_stb = 0; wr_data = 0;
    step(); step();
    chk("R2 held read sets once", int'(rd_data[6]), 0);
    idle(); step();
    sel = 1; rd_stb = 1; step(); idle();
    step();
    chk("R2 new read sets", int'(rd_data[6]), 1);
    wr(8'h00);
    chk("R3 write 0 keeps sem", int'(rd_data[6]), 1);
    wr(8'h40);
    chk("R3 release", int'(rd_data[6]), 0);
    sel = 1; rd_stb = 1; wr_stb = 1; wr_data = 8'h40; step(); idle();
    chk("R3 read wins", int'(rd_data[6]), 1);
    wr(8'h40);

    // R7: alert
    alert_gpio = 1; alert_evt = 1; step(); idle();
    chk("R7 gpio blocks", int'(rd_data[5]), 0);
    alert_gpio = 0; alert_evt = 1; step(); idle();
    chk("R7 alert set", int'(rd_data[5]), 1);
    chk("R9 alert not routed", int'(irq), 0);
    alert_to_int = 1; step();
    chk("R9 alert routed", int'(irq), 1);
    rst_n = 0; step(); step(); rst_n = 1; repeat (3) step();
    chk("R7 main reset keeps alert", int'(rd_data[5]), 1);
    rsm_rst_n = 0; step(); step(); rsm_rst_n = 1; repeat (3) step();
    chk("R7 resume reset clears", int'(rd_data[5]), 0);
    alert_evt = 1; step(); idle();
    wr(8'h20);
    chk("R7 write clears", int'(rd_data[5]), 0);
    repeat (2) step();

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule